// File: doc/BRIEF.md
# Block Huffman Encoding Unit

This unit takes one 8x8 block of quantized transform coefficients and turns it into a sequence of variable-length code entries. A host drives it through three operations, issued in a fixed order for each block. First, a block load delivers four 16-bit coefficients per beat until all 64 are held. Next, an encode operation supplies the DC value of the previous block and a luminance/chrominance class. The unit then codes the DC difference and run-length codes the AC terms in zigzag order. Last, a move-result operation pops the produced entries one at a time.

Each result carries a Huffman code with its length and an amplitude field with its length. A flag tells the host whether another result will follow. The Huffman codes come from a writable table, indexed by class, by DC/AC and by symbol, which the host fills through a plain write port. Entries go into an internal queue that is deep enough for the worst case of one block. From the accepted encode until the last entry is popped, the unit reports busy, and it ignores any new load or encode while busy.

Top module: `huff_enc_unit`

## Requirements
- R1: After reset, busy, res_valid and blk_ready are all 0.
- R2: A load beat is taken only when busy is 0 and the block is not yet complete. In beat b, lane l (bits 16l+15..16l of ld_data) is stored as coefficient 4b+l in row-major order. After 16 taken beats, blk_ready is 1. Any other beat has no effect.
- R3: enc_start is accepted only when blk_ready is 1 and busy is 0. When accepted, blk_ready clears and busy is 1 from the next cycle until the cycle after the final result is popped. An enc_start that is not accepted has no effect.
- R4: The first result codes d = coefficient0 - enc_prev_dc. Its size s is the bit count of |d|. Its code and length come from the DC table entry for symbol s. Its amplitude is the low s bits of d when d >= 0, and of d-1 otherwise, with res_amp_len = s.
- R5: AC coefficients are visited in zigzag order (positions 1, 8, 16, 9, 2, 3, 10, ...). Each nonzero value v, preceded by r zeros (r < 16), produces AC symbol r*16+s(v) with the amplitude of v coded as in R4.
- R6: When a nonzero AC value is preceded by 16 or more zeros, one entry with AC symbol 0xF0 and amplitude length 0 is produced for each 16 zeros, before the value's own entry.
- R7: When the last zigzag coefficient (position 63) is zero, the final result is AC symbol 0x00 with amplitude length 0, and no 0xF0 entries are produced for the trailing zeros. When position 63 is nonzero, no 0x00 entry is produced.
- R8: Results are presented in production order while res_valid is 1, and mv_req pops the head. res_more is 1 exactly when another result of the same block will follow the one being presented.
- R9: enc_chroma selects the table set: 0 for luminance, 1 for chrominance.
- R10: A table write stores tbl_code and tbl_len at {tbl_chroma, tbl_ac, tbl_sym}. Later encodes use the new entry.
- R11: mv_req has no effect while res_valid is 0. The result queue holds a full block of 64 entries without loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_chroma | input | 1 | Table class for the write (1 = chrominance) |
| tbl_ac | input | 1 | Table kind for the write (1 = AC, 0 = DC) |
| tbl_sym | input | 8 | Symbol index for the write |
| tbl_code | input | 16 | Code bits, right-aligned |
| tbl_len | input | 5 | Code length in bits |
| ld_valid | input | 1 | Load beat present |
| ld_data | input | 64 | Four coefficients, lane 0 in the low bits |
| enc_start | input | 1 | Encode request |
| enc_prev_dc | input | 16 | Previous block DC value, signed |
| enc_chroma | input | 1 | Class for this encode (1 = chrominance) |
| busy | output | 1 | Encode or drain in progress |
| blk_ready | output | 1 | All 64 coefficients loaded |
| mv_req | input | 1 | Pop the head result |
| res_valid | output | 1 | A result is presented |
| res_code | output | 16 | Head result code bits |
| res_len | output | 5 | Head result code length |
| res_amp | output | 11 | Head result amplitude bits |
| res_amp_len | output | 5 | Head result amplitude length |
| res_more | output | 1 | Another result follows the head |

## Verification
On every cycle, the embedded properties check several things. The result queue never overflows. The AC scan never sits on the DC position. The zero-run count stays in range. Busy rises only after an encode request, popping a final result always releases busy, and the block-ready state holds still while busy. The bench scenarios alone can show the coding itself: the DC difference and its ones'-complement amplitude, the zigzag visit order, the 0xF0 insertion and trailing end-of-block rules, the class selection, the effect of table rewrites, and that loads and encodes issued while busy leave no trace.

// File: rtl/huff_pkg.sv
package huff_pkg;

   localparam int COEF_W = 16;
   localparam int CODE_W = 16;
   localparam int LEN_W  = 5;
   localparam int AMP_W  = 11;
   localparam int SIZE_W = 5;
   localparam int SYM_W  = 8;

   typedef struct packed {
      logic [CODE_W-1:0] code;
      logic [LEN_W-1:0]  len;
      logic [AMP_W-1:0]  amp;
      logic [SIZE_W-1:0] alen;
   } res_t;

   // bit count of the magnitude of a signed value
   function automatic logic [SIZE_W-1:0] size_of(input logic signed [COEF_W:0] v);
      logic [COEF_W:0] mag;
      logic [SIZE_W-1:0] s;
      mag = v[COEF_W] ? $unsigned(-v) : $unsigned(v);
      s = '0;
      for (int i = 0; i <= COEF_W; i++)
         if (mag[i]) s = SIZE_W'(i + 1);
      return s;
   endfunction

   // low s bits of v, or of v-1 when negative
   function automatic logic [AMP_W-1:0] amp_of(input logic signed [COEF_W:0] v,
                                              input logic [SIZE_W-1:0] s);
      logic [COEF_W:0] t;
      logic [AMP_W-1:0] a;
      t = v[COEF_W] ? $unsigned(v - 17'sd1) : $unsigned(v);
      for (int i = 0; i < AMP_W; i++)
         a[i] = t[i] && (i < int'(s));
      return a;
   endfunction

   // row-major position of the k-th coefficient of a diagonal scan
   function automatic int zz_pos(input int k, input int dim);
      int r, c;
      r = 0;
      c = 0;
      for (int i = 0; i < k; i++) begin
         if (((r + c) % 2) == 0) begin
            if (c == dim - 1) r++;
            else if (r == 0) c++;
            else begin r--; c++; end
         end else begin
            if (r == dim - 1) c++;
            else if (c == 0) r++;
            else begin r++; c--; end
         end
      end
      return r * dim + c;
   endfunction

endpackage

// File: rtl/huff_blk_buf.sv
module huff_blk_buf
   import huff_pkg::*;
#(
   parameter int LANES = 4,
   parameter int NCOEF = 64
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      ld_en,
   input  logic [LANES*COEF_W-1:0]   ld_data,
   input  logic                      clr,
   input  logic [$clog2(NCOEF)-1:0]  rd_idx,
   output logic [COEF_W-1:0]         rd_coef,
   output logic                      full
);
   localparam int BEATS = NCOEF / LANES;
   localparam int BW    = (BEATS > 1) ? $clog2(BEATS) : 1;
   localparam int IW    = $clog2(NCOEF);

   if ((NCOEF % LANES) != 0) begin : g_bad_lanes
      $error("NCOEF must be a multiple of LANES");
   end

   logic [COEF_W-1:0] mem [NCOEF];
   logic [COEF_W-1:0] lane [LANES];
   logic [BW-1:0]     beat;
   logic              take;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign lane[l] = ld_data[l*COEF_W +: COEF_W];
   end

   assign take = ld_en && !full;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         beat <= '0;
         full <= 1'b0;
      end else if (clr) begin
         beat <= '0;
         full <= 1'b0;
      end else if (take) begin
         beat <= (beat == BW'(BEATS - 1)) ? '0 : beat + 1'b1;
         if (beat == BW'(BEATS - 1)) full <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (take)
         for (int l = 0; l < LANES; l++)
            mem[IW'(int'(beat) * LANES + l)] <= lane[l];
   end

   assign rd_coef = mem[rd_idx];

endmodule

// File: rtl/huff_code_tbl.sv
module huff_code_tbl
   import huff_pkg::*;
(
   input  logic              clk,
   input  logic              we,
   input  logic              w_chroma,
   input  logic              w_ac,
   input  logic [SYM_W-1:0]  w_sym,
   input  logic [CODE_W-1:0] w_code,
   input  logic [LEN_W-1:0]  w_len,
   input  logic              r_chroma,
   input  logic              r_ac,
   input  logic [SYM_W-1:0]  r_sym,
   output logic [CODE_W-1:0] r_code,
   output logic [LEN_W-1:0]  r_len
);
   localparam int ENTRIES = 4 << SYM_W;
   localparam int AW      = SYM_W + 2;

   logic [CODE_W+LEN_W-1:0] mem [ENTRIES];

   always_ff @(posedge clk) begin
      if (we) mem[{w_chroma, w_ac, w_sym}] <= {w_code, w_len};
   end

   logic [AW-1:0] ra;
   assign ra = {r_chroma, r_ac, r_sym};
   assign {r_code, r_len} = mem[ra];

endmodule

// File: rtl/huff_rl_engine.sv
module huff_rl_engine
   import huff_pkg::*;
#(
   parameter int DIM = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start,
   input  logic [COEF_W-1:0]             prev_dc,
   input  logic                          chroma,
   output logic [$clog2(DIM*DIM)-1:0]    rd_idx,
   input  logic [COEF_W-1:0]             rd_coef,
   output logic                          lk_chroma,
   output logic                          lk_ac,
   output logic [SYM_W-1:0]              lk_sym,
   input  logic [CODE_W-1:0]             lk_code,
   input  logic [LEN_W-1:0]              lk_len,
   output logic                          push,
   output res_t                          push_data,
   output logic                          busy
);
   localparam int NCOEF = DIM * DIM;
   localparam int IW    = $clog2(NCOEF);
   localparam int RW    = IW + 1;
   localparam logic [IW-1:0] LAST = IW'(NCOEF - 1);

   typedef enum logic [1:0] {E_IDLE, E_DC, E_AC, E_EOB} est_t;

   est_t              st;
   logic [IW-1:0]     k;
   logic [RW-1:0]     run;
   logic [COEF_W-1:0] prev_q;
   logic              chroma_q;
   logic [IW-1:0]     zz_tab [NCOEF];

   for (genvar i = 0; i < NCOEF; i++) begin : g_zz
      assign zz_tab[i] = IW'(zz_pos(i, DIM));
   end

   logic signed [COEF_W:0] val;
   logic [SIZE_W-1:0]      sz;
   logic [AMP_W-1:0]       amp;
   logic                   zero, long_run;

   assign rd_idx   = (st == E_DC) ? '0 : zz_tab[k];
   assign zero     = (rd_coef == '0);
   assign long_run = (run >= RW'(16));
   assign val      = (st == E_DC) ? ($signed({rd_coef[COEF_W-1], rd_coef}) -
                                     $signed({prev_q[COEF_W-1], prev_q}))
                                  : $signed({rd_coef[COEF_W-1], rd_coef});
   assign sz       = size_of(val);
   assign amp      = amp_of(val, sz);

   assign lk_chroma = chroma_q;
   assign lk_ac     = (st != E_DC);
   assign busy      = (st != E_IDLE);

   always_comb begin
      push   = 1'b0;
      lk_sym = '0;
      push_data.code = lk_code;
      push_data.len  = lk_len;
      push_data.amp  = '0;
      push_data.alen = '0;
      unique case (st)
         E_DC: begin
            push = 1'b1;
            lk_sym = SYM_W'(sz);
            push_data.amp  = amp;
            push_data.alen = sz;
         end
         E_AC: begin
            if (!zero) begin
               push = 1'b1;
               if (long_run) lk_sym = 8'hF0;
               else begin
                  lk_sym = {run[3:0], sz[3:0]};
                  push_data.amp  = amp;
                  push_data.alen = sz;
               end
            end
         end
         E_EOB: push = 1'b1;
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= E_IDLE;
         k        <= '0;
         run      <= '0;
         prev_q   <= '0;
         chroma_q <= 1'b0;
      end else begin
         unique case (st)
            E_IDLE: if (start) begin
               prev_q   <= prev_dc;
               chroma_q <= chroma;
               st       <= E_DC;
            end
            E_DC: begin
               k   <= IW'(1);
               run <= '0;
               st  <= E_AC;
            end
            E_AC: begin
               if (zero) begin
                  run <= run + 1'b1;
                  if (k == LAST) st <= E_EOB;
                  else k <= k + 1'b1;
               end else if (long_run) begin
                  run <= run - RW'(16);
               end else begin
                  run <= '0;
                  if (k == LAST) st <= E_IDLE;
                  else k <= k + 1'b1;
               end
            end
            E_EOB: st <= E_IDLE;
            default: st <= E_IDLE;
         endcase
      end
   end

   // R5
   ac_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == E_AC) |-> (k != '0));

   // R6
   run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == E_AC) |-> (run < RW'(NCOEF)));

endmodule

// File: rtl/huff_res_fifo.sv
module huff_res_fifo
   import huff_pkg::*;
#(
   parameter int DEPTH = 64
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   push,
   input  res_t                   din,
   input  logic                   pop,
   output res_t                   dout,
   output logic [$clog2(DEPTH):0] count
);
   localparam int AW = $clog2(DEPTH);

   if ((1 << AW) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two");
   end

   res_t          mem [DEPTH];
   logic [AW-1:0] wp, rp;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (push) wp <= wp + 1'b1;
         if (pop)  rp <= rp + 1'b1;
         count <= count + (AW+1)'(push) - (AW+1)'(pop);
      end
   end

   always_ff @(posedge clk) begin
      if (push) mem[wp] <= din;
   end

   assign dout = mem[rp];

   // R11
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push && !pop |-> (count < (AW+1)'(DEPTH)));

endmodule

// File: rtl/huff_enc_unit.sv
module huff_enc_unit
   import huff_pkg::*;
#(
   parameter int DIM        = 8,
   parameter int LANES      = 4,
   parameter int FIFO_DEPTH = 64
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    tbl_we,
   input  logic                    tbl_chroma,
   input  logic                    tbl_ac,
   input  logic [7:0]              tbl_sym,
   input  logic [15:0]             tbl_code,
   input  logic [4:0]              tbl_len,
   input  logic                    ld_valid,
   input  logic [LANES*16-1:0]     ld_data,
   input  logic                    enc_start,
   input  logic [15:0]             enc_prev_dc,
   input  logic                    enc_chroma,
   output logic                    busy,
   output logic                    blk_ready,
   input  logic                    mv_req,
   output logic                    res_valid,
   output logic [15:0]             res_code,
   output logic [4:0]              res_len,
   output logic [10:0]             res_amp,
   output logic [4:0]              res_amp_len,
   output logic                    res_more
);
   localparam int NCOEF = DIM * DIM;
   localparam int IW    = $clog2(NCOEF);
   localparam int CW    = $clog2(FIFO_DEPTH) + 1;

   if (FIFO_DEPTH < NCOEF) begin : g_bad_fifo
      $error("FIFO_DEPTH must hold one full block of results");
   end

   logic              eng_busy, start_ok, load_ok, pop;
   logic [IW-1:0]     rd_idx;
   logic [COEF_W-1:0] rd_coef;
   logic              lk_chroma, lk_ac;
   logic [SYM_W-1:0]  lk_sym;
   logic [CODE_W-1:0] lk_code;
   logic [LEN_W-1:0]  lk_len;
   logic              push;
   res_t              push_data, head;
   logic [CW-1:0]     count;

   assign busy     = eng_busy || (count != '0);
   assign start_ok = enc_start && blk_ready && !busy;
   assign load_ok  = ld_valid && !busy;
   assign pop      = mv_req && (count != '0);

   huff_blk_buf #(.LANES(LANES), .NCOEF(NCOEF)) u_buf (
      .clk, .rst_n, .ld_en(load_ok), .ld_data, .clr(start_ok),
      .rd_idx, .rd_coef, .full(blk_ready));

   huff_code_tbl u_tbl (
      .clk, .we(tbl_we), .w_chroma(tbl_chroma), .w_ac(tbl_ac), .w_sym(tbl_sym),
      .w_code(tbl_code), .w_len(tbl_len), .r_chroma(lk_chroma), .r_ac(lk_ac),
      .r_sym(lk_sym), .r_code(lk_code), .r_len(lk_len));

   huff_rl_engine #(.DIM(DIM)) u_eng (
      .clk, .rst_n, .start(start_ok), .prev_dc(enc_prev_dc), .chroma(enc_chroma),
      .rd_idx, .rd_coef, .lk_chroma, .lk_ac, .lk_sym, .lk_code, .lk_len,
      .push, .push_data, .busy(eng_busy));

   huff_res_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
      .clk, .rst_n, .push, .din(push_data), .pop, .dout(head), .count);

   assign res_valid   = (count != '0);
   assign res_code    = head.code;
   assign res_len     = head.len;
   assign res_amp     = head.amp;
   assign res_amp_len = head.alen;
   assign res_more    = (count > CW'(1)) || eng_busy;

   // R3
   busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(enc_start));

   // R8
   last_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_more && mv_req) |=> !busy);

   // R2
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (blk_ready == $past(blk_ready)));

endmodule

// File: tb/huff_enc_unit_tb.sv
module huff_enc_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tbl_we = 0, tbl_chroma = 0, tbl_ac = 0;
   logic [7:0]  tbl_sym = 0;
   logic [15:0] tbl_code = 0;
   logic [4:0]  tbl_len = 0;
   logic        ld_valid = 0;
   logic [63:0] ld_data = 0;
   logic        enc_start = 0, enc_chroma = 0;
   logic [15:0] enc_prev_dc = 0;
   logic        busy, blk_ready, mv_req = 0, res_valid, res_more;
   logic [15:0] res_code;
   logic [4:0]  res_len, res_amp_len;
   logic [10:0] res_amp;

   always #5 clk = ~clk;

   huff_enc_unit u_dut (.*);

   int checks = 0, errors = 0;
   int blk [64];
   int zzb [64];
   int sh_code [1024];
   int sh_len  [1024];
   int e_code [80], e_len [80], e_amp [80], e_alen [80];
   int e_n;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int isize(input int v);
      int m = (v < 0) ? -v : v;
      int s = 0;
      while (m > 0) begin s++; m = m >> 1; end
      return s;
   endfunction

   function automatic int iamp(input int v, input int s);
      int t = (v < 0) ? v - 1 : v;
      return t & ((1 << s) - 1) & 32'h7FF;
   endfunction

   task automatic add_res(input int ch, input int ac, input int sym, input int amp, input int alen);
      int a = ch * 512 + ac * 256 + sym;
      e_code[e_n] = sh_code[a];
      e_len[e_n]  = sh_len[a];
      e_amp[e_n]  = amp;
      e_alen[e_n] = alen;
      e_n++;
   endtask

   task automatic model(input int prev, input int ch);
      int d, s, run, v;
      e_n = 0;
      d = blk[0] - prev;
      s = isize(d);
      add_res(ch, 0, s, iamp(d, s), s);
      run = 0;
      for (int k = 1; k < 64; k++) begin
         v = blk[zzb[k]];
         if (v == 0) run++;
         else begin
            while (run >= 16) begin add_res(ch, 1, 8'hF0, 0, 0); run -= 16; end
            s = isize(v);
            add_res(ch, 1, run * 16 + s, iamp(v, s), s);
            run = 0;
         end
      end
      if (blk[zzb[63]] == 0) add_res(ch, 1, 0, 0, 0);
   endtask

   task automatic wr_entry(input int ch, input int ac, input int sym, input int code, input int len);
      @(negedge clk);
      tbl_we = 1; tbl_chroma = ch[0]; tbl_ac = ac[0]; tbl_sym = 8'(sym);
      tbl_code = 16'(code); tbl_len = 5'(len);
      sh_code[ch * 512 + ac * 256 + sym] = code & 16'hFFFF;
      sh_len[ch * 512 + ac * 256 + sym]  = len & 5'h1F;
      @(negedge clk);
      tbl_we = 0;
   endtask

   task automatic load_block();
      for (int b = 0; b < 16; b++) begin
         @(negedge clk);
         ld_valid = 1;
         for (int l = 0; l < 4; l++) ld_data[l*16 +: 16] = 16'(blk[b*4 + l]);
      end
      @(negedge clk);
      ld_valid = 0;
   endtask

   task automatic encode_and_drain(input int prev, input int ch, input string req);
      int idx, guard;
      bit ok;
      model(prev, ch);
      load_block();
      chk(blk_ready == 1'b1, "R2 blk_ready after 16 beats", int'(blk_ready), 1);
      enc_start = 1; enc_prev_dc = 16'(prev); enc_chroma = ch[0];
      @(negedge clk);
      enc_start = 0;
      chk(busy == 1'b1 && blk_ready == 1'b0, "R3 busy after accepted start", int'(busy), 1);
      idx = 0; guard = 0;
      while (idx < e_n && guard < 400) begin
         mv_req = 0;
         if (res_valid) begin
            ok = (int'(res_code) == e_code[idx]) && (int'(res_len) == e_len[idx]) &&
                 (int'(res_amp) == e_amp[idx]) && (int'(res_amp_len) == e_alen[idx]) &&
                 (res_more == (idx < e_n - 1));
            if (!ok)
               $display("  at result %0d: len %0d/%0d amp %0d/%0d alen %0d/%0d more %0d", idx,
                        res_len, e_len[idx], res_amp, e_amp[idx], res_amp_len, e_alen[idx], res_more);
            chk(ok, req, int'(res_code), e_code[idx]);
            idx++;
            mv_req = 1;
         end
         @(negedge clk);
         guard++;
      end
      mv_req = 0;
      chk(idx == e_n, "R8 result count", idx, e_n);
      chk(busy == 1'b0 && res_valid == 1'b0, "R3 busy clears after last pop", int'(busy), 0);
   endtask

   task automatic t_reset();
      chk(busy == 0 && res_valid == 0 && blk_ready == 0, "R1 reset state",
          int'({busy, res_valid, blk_ready}), 0);
   endtask

   task automatic t_zero_block();
      for (int i = 0; i < 64; i++) blk[i] = 0;
      encode_and_drain(0, 0, "R7 all-zero block gives DC size 0 then end-of-block");
   endtask

   task automatic t_dense();
      for (int i = 0; i < 64; i++) blk[i] = (i % 2) ? -(i + 1) : i + 3;
      encode_and_drain(100, 0, "R4 R5 dense block, negative DC difference, full queue");
   endtask

   task automatic t_long_run();
      for (int i = 0; i < 64; i++) blk[i] = 0;
      blk[0] = -50;
      blk[zzb[20]] = 5;
      blk[zzb[63]] = -2;
      encode_and_drain(-50, 0, "R6 R7 zero-run escapes, nonzero last coefficient");
   endtask

   task automatic t_chroma();
      for (int i = 0; i < 64; i++) blk[i] = (i % 7 == 0) ? 9 - i : 0;
      encode_and_drain(-300, 1, "R9 chrominance tables selected");
      encode_and_drain(-300, 0, "R9 luminance tables selected");
   endtask

   task automatic t_ignored();
      for (int i = 0; i < 64; i++) blk[i] = (i < 6) ? i + 1 : 0;
      // start with no loaded block: no effect (R3)
      @(negedge clk);
      enc_start = 1;
      @(negedge clk);
      enc_start = 0;
      chk(busy == 0, "R3 start without block ignored", int'(busy), 0);
      // pop with empty queue: no effect (R11)
      mv_req = 1;
      @(negedge clk);
      mv_req = 0;
      chk(res_valid == 0 && busy == 0, "R11 pop on empty ignored", int'(res_valid), 0);
      model(7, 0);
      load_block();
      enc_start = 1; enc_prev_dc = 16'd7; enc_chroma = 0;
      @(negedge clk);
      enc_start = 0;
      // loads and start while busy are ignored (R2, R3)
      ld_valid = 1; ld_data = 64'h7777_6666_5555_4444;
      @(negedge clk);
      @(negedge clk);
      ld_valid = 0;
      enc_start = 1;
      @(negedge clk);
      enc_start = 0;
      chk(blk_ready == 0, "R2 load while busy ignored", int'(blk_ready), 0);
      while (busy) begin
         mv_req = res_valid;
         @(negedge clk);
      end
      mv_req = 0;
      @(negedge clk);
      chk(busy == 0 && res_valid == 0, "R3 start while busy ignored", int'(busy), 0);
      for (int i = 0; i < 64; i++) blk[i] = (i == 1 || i == 62) ? -4 : 0;
      encode_and_drain(0, 0, "R2 later block unaffected by ignored beats");
   endtask

   task automatic t_rewrite();
      for (int i = 0; i < 64; i++) blk[i] = 0;
      blk[0] = 3;
      wr_entry(0, 0, 2, 16'hBEEF, 13);
      wr_entry(0, 1, 0, 16'h0005, 4);
      encode_and_drain(0, 0, "R10 rewritten table entries used");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int n = 0;
      for (int s = 0; s < 15; s++) begin
         if (s % 2 == 0) begin
            for (int r = (s < 7 ? s : 7); r >= (s > 7 ? s - 7 : 0); r--) begin zzb[n] = r * 8 + (s - r); n++; end
         end else begin
            for (int r = (s > 7 ? s - 7 : 0); r <= (s < 7 ? s : 7); r++) begin zzb[n] = r * 8 + (s - r); n++; end
         end
      end
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      for (int ch = 0; ch < 2; ch++)
         for (int ac = 0; ac < 2; ac++)
            for (int sym = 0; sym < 256; sym++) begin
               @(negedge clk);
               tbl_we = 1; tbl_chroma = ch[0]; tbl_ac = ac[0]; tbl_sym = 8'(sym);
               tbl_code = 16'((ch << 15) | (ac << 14) | ((sym * 37 + 5) & 16'h3FFF));
               tbl_len = 5'(1 + (sym + ch * 5 + ac * 9) % 16);
               sh_code[ch * 512 + ac * 256 + sym] = int'(tbl_code);
               sh_len[ch * 512 + ac * 256 + sym]  = int'(tbl_len);
            end
      @(negedge clk);
      tbl_we = 0;
      t_zero_block();
      t_dense();
      t_long_run();
      t_chroma();
      t_ignored();
      t_rewrite();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule